// File: doc/BRIEF.md
# Three-Operand Integer ALU

This block is the integer execution unit of a 32-bit load/store machine with three register operands. Each instruction gives it two register operands, a 5-bit shift amount, a 16-bit immediate with a flag that selects it in place of the second register, and a 4-bit operation code. From these it produces a 32-bit result and a flag that marks two's-complement overflow on the trapping add and subtract operations.

It supports addition and subtraction in trapping and non-trapping forms, the four bitwise logic functions, shifts with zero fill, signed and unsigned set-less-than, and loading the upper half of a word from the immediate. Any operation that takes a second operand also has an immediate form. Each operation has fixed rules for widening the immediate. There is no subtract-immediate: the caller subtracts a constant by adding its negation. There is no NOT: the caller uses NOR with a zero operand. The block is purely combinational, so the result is valid in the same cycle as the operands.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (ADD), 1 (ADDU), 2 (SUB) and 3 (SUBU) produce `a_i + B` or `a_i - B`, modulo 2^32, where B is the second operand.
- R2: `ovf_o` is 1 only for codes 0 and 2, and only when the true signed result does not fit in 32 bits. ADDU, SUBU and every other code always drive `ovf_o` to 0.
- R3: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) apply the named function bit by bit. NOR with a zero `a_i` returns the bitwise inverse of B.
- R4: Codes 8 (SLT, signed) and 9 (SLTU, unsigned) return 1 when `a_i` is less than B and 0 otherwise. Bits 31:1 of the result are always zero.
- R5: When `imm_sel_i` is 1, the widened immediate replaces `b_i` as B. Codes 0, 1, 2, 3, 8 and 9 sign-extend the immediate, including the unsigned compare. Codes 4 to 7 zero-extend it.
- R6: Codes 10 (SLL) and 11 (SRL) shift `b_i` left or right by `shamt_i` (0 to 31) and fill the vacated bits with zeros. `imm_sel_i` and `imm_i` have no effect on these codes.
- R7: Code 12 (LUI) returns `imm_i` in bits 31:16 and zeros in bits 15:0, whatever the values of `a_i`, `b_i` and `imm_sel_i`.
- R8: Codes 13 to 15 are reserved. They return a result of zero with `ovf_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand; also the shift source |
| imm_i | input | 16 | Immediate field |
| imm_sel_i | input | 1 | Use the widened immediate in place of `b_i` |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of ADD or SUB |

## Verification
Some properties must hold on every evaluation, and the assertions check these:
- the compare result has its upper bits clear;
- LUI places the immediate in the upper half;
- overflow appears only on the trapping add and subtract;
- reserved codes give zero;
- NOR with a zero operand inverts;
- a zero shift passes the operand through;
- non-trapping register addition is consistent.

Other behaviour depends on arithmetic values, and only the bench's scenarios can show it:
- the exact overflow boundaries at the most positive and most negative values;
- sign extension of the immediate in the unsigned compare;
- zero extension in the logic immediates;
- that the immediate is ignored by the shifts.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_ADDU = 4'd1,
    ALU_SUB  = 4'd2,
    ALU_SUBU = 4'd3,
    ALU_AND  = 4'd4,
    ALU_OR   = 4'd5,
    ALU_XOR  = 4'd6,
    ALU_NOR  = 4'd7,
    ALU_SLT  = 4'd8,
    ALU_SLTU = 4'd9,
    ALU_SLL  = 4'd10,
    ALU_SRL  = 4'd11,
    ALU_LUI  = 4'd12
  } alu_op_e;

  // Operations whose immediate form zero-extends the immediate.
  function automatic logic op_zero_ext(input logic [3:0] op);
    return (op == ALU_AND) || (op == ALU_OR) || (op == ALU_XOR) || (op == ALU_NOR);
  endfunction

  // Operations that run the adder in subtract mode.
  function automatic logic op_uses_sub(input logic [3:0] op);
    return (op == ALU_SUB) || (op == ALU_SUBU) || (op == ALU_SLT) || (op == ALU_SLTU);
  endfunction

endpackage

// File: rtl/int_alu_opsel.sv
module int_alu_opsel
  import int_alu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] b_i,
  input  logic [IW-1:0] imm_i,
  input  logic          imm_sel_i,
  output logic [DW-1:0] b_eff_o
);
  localparam int PAD = DW - IW;

  logic [DW-1:0] imm_sx;
  logic [DW-1:0] imm_zx;

  assign imm_sx = {{PAD{imm_i[IW-1]}}, imm_i};
  assign imm_zx = {{PAD{1'b0}}, imm_i};

  always_comb begin
    if (!imm_sel_i) begin
      b_eff_o = b_i;
    end else if (op_zero_ext(op_i)) begin
      b_eff_o = imm_zx;
    end else begin
      b_eff_o = imm_sx;
    end
  end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          ovf_o,
  output logic          lt_s_o,
  output logic          lt_u_o
);
  logic [DW-1:0] b_x;
  logic [DW:0]   wide;
  logic          carry;

  assign b_x   = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_x} + {{DW{1'b0}}, sub_i};
  assign sum_o = wide[DW-1:0];
  assign carry = wide[DW];

  // Overflow: both addends share a sign that the sum does not.
  assign ovf_o  = (a_i[DW-1] == b_x[DW-1]) && (sum_o[DW-1] != a_i[DW-1]);
  // Signed less-than: sign of difference corrected by overflow.
  assign lt_s_o = sum_o[DW-1] ^ ovf_o;
  // Unsigned less-than: a borrow happened (no carry out of a + ~b + 1).
  assign lt_u_o = ~carry;
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int DW = 32
) (
  input  logic [1:0]    fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] d_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] d_rev;
  logic [DW-1:0] y_rev;
  logic [DW-1:0] stg [0:SW];

  // Right shifts reuse the left-shift array on the bit-reversed word.
  for (genvar k = 0; k < DW; k++) begin : g_rev
    assign d_rev[k] = d_i[DW-1-k];
    assign y_rev[k] = stg[SW][DW-1-k];
  end

  assign stg[0] = right_i ? d_rev : d_i;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int SH = 1 << i;
    assign stg[i+1] = amt_i[i] ? {stg[i][DW-1-SH:0], {SH{1'b0}}} : stg[i];
  end

  assign y_o = right_i ? y_rev : stg[SW];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16,
  localparam int SW = $clog2(DW)
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [IW-1:0] imm_i,
  input  logic          imm_sel_i,
  input  logic [SW-1:0] shamt_i,
  output logic [DW-1:0] result_o,
  output logic          ovf_o
);
  localparam int LOW = DW - IW;

  logic [DW-1:0] b_eff;
  logic [DW-1:0] sum;
  logic          ovf_raw;
  logic          lt_s;
  logic          lt_u;
  logic [DW-1:0] logic_y;
  logic [DW-1:0] shift_y;

  int_alu_opsel #(.DW(DW), .IW(IW)) u_opsel (
    .op_i      (op_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .imm_sel_i (imm_sel_i),
    .b_eff_o   (b_eff)
  );

  int_alu_addsub #(.DW(DW)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_eff),
    .sub_i  (op_uses_sub(op_i)),
    .sum_o  (sum),
    .ovf_o  (ovf_raw),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  int_alu_logic #(.DW(DW)) u_logic (
    .fn_i (op_i[1:0]),
    .a_i  (a_i),
    .b_i  (b_eff),
    .y_o  (logic_y)
  );

  int_alu_shift #(.DW(DW)) u_shift (
    .d_i     (b_i),
    .amt_i   (shamt_i),
    .right_i (op_i == ALU_SRL),
    .y_o     (shift_y)
  );

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    case (op_i)
      ALU_ADD, ALU_SUB: begin
        result_o = sum;
        ovf_o    = ovf_raw;
      end
      ALU_ADDU, ALU_SUBU:               result_o = sum;
      ALU_AND, ALU_OR, ALU_XOR, ALU_NOR: result_o = logic_y;
      ALU_SLT:                          result_o = {{(DW-1){1'b0}}, lt_s};
      ALU_SLTU:                         result_o = {{(DW-1){1'b0}}, lt_u};
      ALU_SLL, ALU_SRL:                 result_o = shift_y;
      ALU_LUI:                          result_o = {imm_i, {LOW{1'b0}}};
      default: begin
        result_o = '0;
        ovf_o    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int DW = 32,
  parameter int IW = 16,
  localparam int SW = $clog2(DW)
) (
  input logic [3:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [IW-1:0] imm_i,
  input logic          imm_sel_i,
  input logic [SW-1:0] shamt_i,
  input logic [DW-1:0] result_o,
  input logic          ovf_o
);
  localparam int LOW = DW - IW;

  always_comb begin
    if (op_i == 4'd1 && !imm_sel_i) begin
      assert_addu_consistent_R1: assert (result_o - b_i == a_i)
        else $error("ADDU result inconsistent");
    end
    if (ovf_o) begin
      assert_no_overflow_R2: assert (op_i == 4'd0 || op_i == 4'd2)
        else $error("overflow on non-trapping code");
    end
    if (op_i == 4'd7 && !imm_sel_i && a_i == '0) begin
      assert_nor_inverts_R3: assert (result_o == ~b_i)
        else $error("NOR with zero did not invert");
    end
    if (op_i == 4'd8 || op_i == 4'd9) begin
      assert_cmp_bool_R4: assert (result_o[DW-1:1] == '0)
        else $error("compare result not boolean");
    end
    if ((op_i == 4'd10 || op_i == 4'd11) && shamt_i == '0) begin
      assert_shift_zero_R6: assert (result_o == b_i)
        else $error("zero shift altered operand");
    end
    if (op_i == 4'd12) begin
      assert_lui_place_R7: assert (result_o == {imm_i, {LOW{1'b0}}})
        else $error("upper immediate misplaced");
    end
    if (op_i >= 4'd13) begin
      assert_reserved_zero_R8: assert (result_o == '0 && !ovf_o)
        else $error("reserved code not zero");
    end
  end
endmodule

bind int_alu int_alu_checker #(.DW(DW), .IW(IW)) u_chk (
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .imm_i     (imm_i),
  .imm_sel_i (imm_sel_i),
  .shamt_i   (shamt_i),
  .result_o  (result_o),
  .ovf_o     (ovf_o)
);

// File: tb/sim_int_alu.sv
`timescale 1ns/1ps
module sim_int_alu;
  logic        clk;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        isel;
  logic [4:0]  sh;
  logic [31:0] result;
  logic        ovf;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int_alu u0 (
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .imm_i     (imm),
    .imm_sel_i (isel),
    .shamt_i   (sh),
    .result_o  (result),
    .ovf_o     (ovf)
  );

  function automatic string tag_of(input int o, input bit s);
    if (s && (o <= 9)) return "R5";
    if (o <= 3) return "R1";
    if (o <= 7) return "R3";
    if (o <= 9) return "R4";
    if (o <= 11) return "R6";
    if (o == 12) return "R7";
    return "R8";
  endfunction

  // Behavioural reference from the requirements.
  task automatic model(input int o, input logic [31:0] ma, mb, input logic [15:0] mi,
                       input bit ms, input int msh, output logic [31:0] r, output bit v);
    logic [31:0] bb;
    longint sa, sb, s;
    bb = mb;
    if (ms) bb = (o >= 4 && o <= 7) ? {16'h0, mi} : {{16{mi[15]}}, mi};
    case (o)
      0, 1:    r = ma + bb;
      2, 3:    r = ma - bb;
      4:       r = ma & bb;
      5:       r = ma | bb;
      6:       r = ma ^ bb;
      7:       r = ~(ma | bb);
      8:       r = ($signed(ma) < $signed(bb)) ? 32'd1 : 32'd0;
      9:       r = (ma < bb) ? 32'd1 : 32'd0;
      10:      r = mb << msh;
      11:      r = mb >> msh;
      12:      r = {mi, 16'h0};
      default: r = 32'h0;
    endcase
    sa = longint'($signed(ma));
    sb = longint'($signed(bb));
    s  = (o == 2) ? sa - sb : sa + sb;
    v  = (o == 0 || o == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
  endtask

  task automatic run(input int o, input logic [31:0] ta, tb_, input logic [15:0] ti,
                     input bit ts, input int tsh);
    logic [31:0] er;
    bit ev;
    @(negedge clk);
    op = 4'(o); a = ta; b = tb_; imm = ti; isel = ts; sh = 5'(tsh);
    model(o, ta, tb_, ti, ts, tsh, er, ev);
    @(posedge clk);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s op=%0d result actual=%h expected=%h", tag_of(o, ts), o, result, er);
    end
    checks++;
    if (ovf !== ev) begin
      errors++;
      $display("FAIL R2 op=%0d ovf actual=%b expected=%b", o, ovf, ev);
    end
  endtask

  initial begin
    op = 4'd0; a = '0; b = '0; imm = '0; isel = 1'b0; sh = '0;
    // All-zero inputs: quiet result
    run(0, 32'h0, 32'h0, 16'h0, 0, 0);
    // R1 wrap / R2 overflow boundaries
    run(0, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0);
    run(1, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0);
    run(1, 32'hFFFFFFFF, 32'h2, 16'h0, 0, 0);
    run(2, 32'h80000000, 32'h1, 16'h0, 0, 0);
    run(2, 32'h0, 32'h80000000, 16'h0, 0, 0);
    run(3, 32'h0, 32'h1, 16'h0, 0, 0);
    run(0, 32'h80000000, 32'h80000000, 16'h0, 0, 0);
    // R3 NOR with zero as inversion
    run(7, 32'h0, 32'h1234ABCD, 16'h0, 0, 0);
    // R4 signed vs unsigned compare
    run(8, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 0);
    run(9, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 0);
    run(8, 32'h5, 32'h5, 16'h0, 0, 0);
    // R5 immediate widening
    run(9, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 1, 0);
    run(4, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 1, 0);
    run(5, 32'h0, 32'hFFFFFFFF, 16'h8001, 1, 0);
    run(0, 32'h5, 32'h0, 16'hFFFF, 1, 0);
    run(0, 32'h80000000, 32'h0, 16'hFFFF, 1, 0);
    run(8, 32'hFFFFFFF0, 32'h0, 16'hFFF8, 1, 0);
    // R6 shift extremes, immediate ignored
    run(10, 32'h0, 32'hFFFFFFFF, 16'h0, 0, 31);
    run(11, 32'h0, 32'hFFFFFFFF, 16'h0, 0, 31);
    run(11, 32'h0, 32'h80000000, 16'hFFFF, 1, 4);
    run(10, 32'h0, 32'hA5A5A5A5, 16'h1234, 1, 0);
    // R7 upper immediate ignores a, b, flag
    run(12, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hBEEF, 1, 7);
    // R8 reserved codes
    for (int o = 13; o < 16; o++) run(o, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 0, 3);
    // Random sweep over every code
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 150; n++) begin
        run(o, $urandom, $urandom, 16'($urandom), bit'($urandom_range(0, 1)),
            int'($urandom_range(0, 31)));
      end
    end
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule